// File: doc/BRIEF.md
# Address Generation Unit with Circular and Bit-Reversed Update

This block computes data-memory addresses for a signal-processing datapath. It owns a small bank of pointer registers. Each request names one register and an update mode. The block returns the address to use for the access, together with the value written back into that register. The memory, the instruction decoder and the arithmetic datapath all sit outside it.

Several update forms share one adder path:
- plain forward and backward stepping, before or after the access, with the offset scaled by the access size;
- stepping by an unscaled index value;
- circular stepping, which keeps a pointer inside a delay-line window of any length. This lets a filter write each new sample over the oldest one without shifting data.
- bit-reversed stepping, which walks FFT data in reversed-index order.

The wrap and the reversed carry are done in hardware, so software never has to correct an address.

A request is accepted in the cycle where `req_valid` is high. The pointer is updated at that clock edge. The address and write-back value are registered and appear one cycle later, qualified by `ea_valid`.

Top module: `agu_top`

## Requirements
- R1: After reset `ea_valid` is 0, `ea_out` and `wb_out` are 0, and every pointer register reads 0.
- R2: `ea_valid` is 1 exactly in the cycle after each request. When no request is made, `ea_valid` is 0 and `ea_out`/`wb_out` keep their values.
- R3: Mode 0 (load) writes `req_off` into the selected pointer. The result gives `ea_out = wb_out = req_off`.
- R4: Mode 1 (post-increment) gives `ea_out` = old pointer and `wb_out` = old + `req_off`·2^`req_size`, where `req_size` 0..3 selects the shift, modulo 2^32.
- R5: Mode 2 (post-decrement) gives `ea_out` = old pointer and `wb_out` = old − `req_off`·2^`req_size`.
- R6: Mode 3 (pre-increment) gives `ea_out = wb_out` = old + `req_off`·2^`req_size`.
- R7: Mode 4 (index step) gives `ea_out` = old and `wb_out` = old + `req_off`. `req_size` has no effect in this mode.
- R8: Mode 5 (circular) gives `ea_out` = old. `wb_out` = `buf_base` + ((old − `buf_base` + s) mod K), where s = signed `req_off`·2^`req_size` and K = `buf_len`. This holds for any K from 1 to 65535, whenever old lies in [base, base+K−1] and |s| ≤ K.
- R9: Mode 6 (bit-reversed) adds 2^(`fft_lg`−1) to the low `fft_lg` bits, with the carry moving from the high bit toward bit 0. Bits at or above `fft_lg` are unchanged, and `fft_lg` = 0 leaves the pointer unchanged. `ea_out` = old.
- R10: Mode 7 (hold) gives `ea_out = wb_out` = old pointer and leaves it unchanged.
- R11: A request writes only the register selected by `req_sel`. Every other pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_sel | input | SEL_W | Pointer register select |
| req_mode | input | 3 | Update mode (0..7) |
| req_size | input | 2 | Offset scale shift (access size) |
| req_off | input | 32 | Offset, index or load value |
| buf_base | input | 32 | Circular window base |
| buf_len | input | 16 | Circular window length K |
| fft_lg | input | 4 | log2 of FFT size for bit-reversed stepping |
| ea_valid | output | 1 | Result valid |
| ea_out | output | 32 | Effective address |
| wb_out | output | 32 | Value written back to the pointer |

## Verification
A request's results appear one edge after it is accepted. `ea_valid`, `ea_out` and `wb_out` are all due in the cycle after the accepting edge. The pointer register changes at that same edge, so a request issued in the very next cycle already sees the new value.

The bench drives each request on the falling clock edge and samples one time unit after the following rising edge. It then drops `req_valid`, so each check reads exactly the cycle in which that request's results are due. Register contents are read back with the hold mode, which itself obeys the same one-cycle rule.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int AW    = 32;
  localparam int LW    = 16;
  localparam int LGMAX = 12;
  localparam int LGW   = $clog2(LGMAX + 1);

  typedef logic [AW-1:0]  addr_t;
  typedef logic [LW-1:0]  len_t;
  typedef logic [LGW-1:0] lg_t;

  typedef enum logic [2:0] {
    M_LOAD    = 3'd0,
    M_POSTINC = 3'd1,
    M_POSTDEC = 3'd2,
    M_PREINC  = 3'd3,
    M_INDEX   = 3'd4,
    M_CIRC    = 3'd5,
    M_BREV    = 3'd6,
    M_HOLD    = 3'd7
  } mode_e;

  // offset scaled by access size
  function automatic addr_t scale_off(addr_t v, logic [1:0] sz);
    return v << sz;
  endfunction

  // circular step: result stays inside [base, base+len-1]
  function automatic addr_t circ_next(addr_t old, addr_t step, addr_t base, len_t len);
    logic signed [AW+1:0] sum, lo, hi, k;
    sum = $signed({2'b00, old}) + $signed({{2{step[AW-1]}}, step});
    lo  = $signed({2'b00, base});
    k   = $signed({{(AW+2-LW){1'b0}}, len});
    hi  = lo + k;
    if (sum >= hi)
      sum = sum - k;
    else if (sum < lo)
      sum = sum + k;
    return sum[AW-1:0];
  endfunction

  // reversed-carry increment over the low lg bits
  function automatic addr_t brev_next(addr_t old, lg_t lg);
    addr_t r;
    logic  c;
    r = old;
    c = 1'b1;
    for (int i = LGMAX - 1; i >= 0; i--) begin
      if (i < int'(lg)) begin
        r[i] = old[i] ^ c;
        c    = old[i] & c;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int NREG  = 8,
  localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SELW-1:0]   sel,
  input  agu_pkg::addr_t    wdata,
  output agu_pkg::addr_t    rdata
);
  agu_pkg::addr_t regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && (int'(sel) == g))
        regs[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (int'(sel) == i) rdata = regs[i];
  end
endmodule

// File: rtl/agu_calc.sv
module agu_calc (
  input  logic [2:0]      mode,
  input  logic [1:0]      size,
  input  agu_pkg::addr_t  off,
  input  agu_pkg::addr_t  old,
  input  agu_pkg::addr_t  base,
  input  agu_pkg::len_t   len,
  input  agu_pkg::lg_t    lg,
  output agu_pkg::addr_t  step,
  output agu_pkg::addr_t  nxt,
  output agu_pkg::addr_t  ea
);
  import agu_pkg::*;

  mode_e m;
  assign m    = mode_e'(mode);
  assign step = scale_off(off, size);

  always_comb begin
    nxt = old;
    ea  = old;
    case (m)
      M_LOAD:    begin nxt = off;        ea = off;        end
      M_POSTINC: begin nxt = old + step; ea = old;        end
      M_POSTDEC: begin nxt = old - step; ea = old;        end
      M_PREINC:  begin nxt = old + step; ea = old + step; end
      M_INDEX:   begin nxt = old + off;  ea = old;        end
      M_CIRC:    begin nxt = circ_next(old, step, base, len); ea = old; end
      M_BREV:    begin nxt = brev_next(old, lg); ea = old; end
      default:   begin nxt = old;        ea = old;        end
    endcase
  end
endmodule

// File: rtl/agu_top.sv
module agu_top #(
  parameter int NREG  = 8,
  localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [SELW-1:0]             req_sel,
  input  logic [2:0]                  req_mode,
  input  logic [1:0]                  req_size,
  input  logic [agu_pkg::AW-1:0]      req_off,
  input  logic [agu_pkg::AW-1:0]      buf_base,
  input  logic [agu_pkg::LW-1:0]      buf_len,
  input  logic [agu_pkg::LGW-1:0]     fft_lg,
  output logic                        ea_valid,
  output logic [agu_pkg::AW-1:0]      ea_out,
  output logic [agu_pkg::AW-1:0]      wb_out
);
  agu_pkg::addr_t old_val, nxt_val, ea_nxt, step_val;

  agu_regfile #(.NREG(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (req_valid),
    .sel   (req_sel),
    .wdata (nxt_val),
    .rdata (old_val)
  );

  agu_calc u_calc (
    .mode (req_mode),
    .size (req_size),
    .off  (req_off),
    .old  (old_val),
    .base (buf_base),
    .len  (buf_len),
    .lg   (fft_lg),
    .step (step_val),
    .nxt  (nxt_val),
    .ea   (ea_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_valid <= 1'b0;
      ea_out   <= '0;
      wb_out   <= '0;
    end else begin
      ea_valid <= req_valid;
      if (req_valid) begin
        ea_out <= ea_nxt;
        wb_out <= nxt_val;
      end
    end
  end
endmodule

// File: rtl/agu_chk.sv
module agu_chk (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic [2:0]              req_mode,
  input logic [agu_pkg::AW-1:0]  old_val,
  input logic [agu_pkg::AW-1:0]  step_val,
  input logic [agu_pkg::AW-1:0]  buf_base,
  input logic [agu_pkg::LW-1:0]  buf_len,
  input logic [agu_pkg::LGW-1:0] fft_lg,
  input logic                    ea_valid,
  input logic [agu_pkg::AW-1:0]  ea_out,
  input logic [agu_pkg::AW-1:0]  wb_out
);
  import agu_pkg::*;

  addr_t len_x, abs_step, low_mask, rel;
  logic  is_post, circ_in;
  assign len_x    = {{(AW-LW){1'b0}}, buf_len};
  assign abs_step = step_val[AW-1] ? (~step_val + 1'b1) : step_val;
  assign low_mask = (addr_t'(1) << fft_lg) - 1'b1;
  assign rel      = old_val - buf_base;
  assign is_post  = (req_mode == M_POSTINC) || (req_mode == M_POSTDEC) ||
                    (req_mode == M_INDEX)   || (req_mode == M_CIRC)    ||
                    (req_mode == M_BREV);
  assign circ_in  = (buf_len != '0) && (old_val >= buf_base) &&
                    (rel < len_x) && (abs_step <= len_x);

  // R2
  lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ea_valid);
  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!ea_valid && $stable(ea_out) && $stable(wb_out)));
  // R4
  post_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_post) |=> (ea_out == $past(old_val)));
  // R6
  pre_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == M_PREINC) |=> (ea_out == wb_out));
  // R8
  circ_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == M_CIRC && circ_in) |=>
      ((wb_out >= $past(buf_base)) && ((wb_out - $past(buf_base)) < $past(len_x))));
  // R9
  brev_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == M_BREV) |=>
      (((wb_out ^ $past(old_val)) & ~$past(low_mask)) == '0));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == M_HOLD) |=> (wb_out == $past(old_val) && ea_out == wb_out));
endmodule

bind agu_top agu_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_mode (req_mode),
  .old_val  (old_val),
  .step_val (step_val),
  .buf_base (buf_base),
  .buf_len  (buf_len),
  .fft_lg   (fft_lg),
  .ea_valid (ea_valid),
  .ea_out   (ea_out),
  .wb_out   (wb_out)
);

// File: tb/sim_agu_top.sv
`timescale 1ns/1ps
module sim_agu_top;
  localparam int NR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_sel = '0;
  logic [2:0]  req_mode = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_off = '0;
  logic [31:0] buf_base = '0;
  logic [15:0] buf_len = '0;
  logic [3:0]  fft_lg = '0;
  logic        ea_valid;
  logic [31:0] ea_out, wb_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] mdl [NR];

  always #2 clk = ~clk;

  agu_top #(.NREG(NR)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
    .req_mode(req_mode), .req_size(req_size), .req_off(req_off),
    .buf_base(buf_base), .buf_len(buf_len), .fft_lg(fft_lg),
    .ea_valid(ea_valid), .ea_out(ea_out), .wb_out(wb_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input int sel, input int mode, input int size, input logic [31:0] off,
                       input logic [31:0] e_ea, input logic [31:0] e_wb, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_sel   = 2'(sel);
    req_mode  = 3'(mode);
    req_size  = 2'(size);
    req_off   = off;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    chk(ea_valid == 1'b1, {tag, " R2 valid"}, 32'(ea_valid), 32'd1);
    chk(ea_out == e_ea, {tag, " ea"}, ea_out, e_ea);
    chk(wb_out == e_wb, {tag, " wb"}, wb_out, e_wb);
    mdl[sel] = e_wb;
  endtask

  // independent reference, circular and bit-reversed handled by callers
  task automatic lin_op(input int sel, input int mode, input int size, input logic [31:0] off, input string tag);
    logic [31:0] o, e_ea, e_wb, sc;
    o  = mdl[sel];
    sc = off * (32'd1 << size);
    case (mode)
      0: begin e_ea = off; e_wb = off; end
      1: begin e_ea = o; e_wb = o + sc; end
      2: begin e_ea = o; e_wb = o - sc; end
      3: begin e_wb = o + sc; e_ea = e_wb; end
      4: begin e_ea = o; e_wb = o + off; end
      default: begin e_ea = o; e_wb = o; end
    endcase
    do_op(sel, mode, size, off, e_ea, e_wb, tag);
  endtask

  function automatic logic [31:0] rev_bits(input int v, input int lg);
    logic [31:0] r = '0;
    for (int k = 0; k < lg; k++) r[k] = v[lg-1-k];
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(ea_valid == 1'b0, "R1 valid", 32'(ea_valid), 0);
    chk(ea_out == '0, "R1 ea", ea_out, 0);
    chk(wb_out == '0, "R1 wb", wb_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NR; i++) lin_op(i, 7, 0, 32'hFFFF, "R1 reg zero");

    // R2 idle cycle holds outputs
    @(posedge clk); #1;
    chk(ea_valid == 1'b0, "R2 idle valid", 32'(ea_valid), 0);
    chk(wb_out == '0, "R2 idle hold", wb_out, 0);

    // R3 load, R11 independence
    for (int i = 0; i < NR; i++) lin_op(i, 0, 0, 32'h1000 * (i + 1) + 32'h10, "R3 load");
    for (int i = 0; i < NR; i++) lin_op(i, 7, 0, '0, "R11 readback");

    // R4 R5 R6 sweep sizes and offsets
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 5; o++) begin
        lin_op(1, 1, s, 32'(o * 3 + 1), "R4 postinc");
        lin_op(2, 2, s, 32'(o * 5 + 2), "R5 postdec");
        lin_op(3, 3, s, 32'(o + 7), "R6 preinc");
      end
    end
    lin_op(0, 0, 0, 32'h0000_0002, "R3 load");
    lin_op(0, 2, 2, 32'h1, "R5 wrap below zero");
    lin_op(0, 1, 3, 32'hFFFF_FFFF, "R4 negative offset");
    // R7 index ignores size
    for (int s = 0; s < 4; s++) lin_op(1, 4, s, 32'(13 + s), "R7 index");
    // R11 untouched registers
    for (int i = 0; i < NR; i++) lin_op(i, 7, 0, '0, "R11 R10 hold");

    // R8 circular, several lengths and steps
    begin
      int ks [5] = '{1, 3, 5, 8, 10};
      int ss [6] = '{1, -1, 2, -3, 8, -8};
      buf_base = 32'h200;
      foreach (ks[a]) begin
        buf_len = 16'(ks[a]);
        foreach (ss[b]) begin
          if ((ss[b] <= ks[a]) && (-ss[b] <= ks[a])) begin
            lin_op(2, 0, 0, 32'h200 + 32'(ks[a] / 2), "R8 setup");
            for (int n = 0; n < 2 * ks[a] + 1; n++) begin
              int rel, nr;
              logic [31:0] o;
              o   = mdl[2];
              rel = int'(o - 32'h200);
              nr  = ((rel + ss[b]) % ks[a] + ks[a]) % ks[a];
              do_op(2, 5, 0, 32'(ss[b]), o, 32'h200 + 32'(nr), "R8 circ");
            end
          end
        end
      end
      // scaled circular step: offset 1, word size => 4, window 10
      buf_len = 16'd10;
      lin_op(2, 0, 0, 32'h205, "R8 setup");
      for (int n = 0; n < 6; n++) begin
        int rel, nr;
        logic [31:0] o;
        o   = mdl[2];
        rel = int'(o - 32'h200);
        nr  = (rel + 4) % 10;
        do_op(2, 5, 2, 32'd1, o, 32'h200 + 32'(nr), "R8 circ scaled");
      end
    end

    // R9 bit-reversed ordering
    for (int lg = 0; lg < 5; lg++) begin
      int j;
      fft_lg = 4'(lg);
      lin_op(3, 0, 0, 32'hABC0_0000, "R9 setup");
      j = 0;
      for (int n = 0; n < (1 << lg) + 1; n++) begin
        logic [31:0] o;
        o = mdl[3];
        j = (lg == 0) ? 0 : (j + 1) % (1 << lg);
        do_op(3, 6, 0, '0, o, 32'hABC0_0000 | rev_bits(j, lg), "R9 brev");
      end
    end

    // R10 hold
    lin_op(3, 7, 1, 32'h55, "R10 hold");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule